// File: doc/BRIEF.md
# PDM Control-Pattern Decoder

This block listens to one channel of a time-multiplexed stereo PDM bit stream and picks out control commands carried inside the audio. A command is an 8-bit byte sent over and over. The decoder turns the selected channel into a serial bit sequence and compares every new bit with the bit eight positions earlier. Once the run of agreeing bits is long enough and the repeating byte is a known command, the block updates a small configuration register. That register holds the gain choice, the sample-rate choice, low-EMI mode, low-latency mode, a persistent mute, and a power-down request.

A separate pattern-mute flag rises as soon as a known command is seen repeating. Downstream audio can therefore be silenced while a setting changes. The flag drops on the first bit that breaks the repetition. The defaults come from a latched four-state strap. They are restored by the reset command, and also by a loss of the PDM clock.

Top module: `pdm_ctl_decoder`

## Requirements
- R1: On reset, the fields take the strap value: `strap_i[1]`=1 selects the 128x rate, `strap_i[0]`=1 selects 5 V gain (`gain_o`=2), else 3.6 V gain (`gain_o`=0); low-EMI, low-latency, mute, pattern mute and power-down are all 0.
- R2: With `lr_sel_i`=0 the bit is taken from `pdm_dat_i` at each rising edge of `pdm_clk_i`. With `lr_sel_i`=1 it is taken at each falling edge. The other channel has no effect.
- R3: Counting starts once eight bits have been taken after reset or after a clock loss. A command takes effect when REPEATS*8 consecutive taken bits (default 1032) have each equalled the bit eight positions earlier. One bit short of that leaves the configuration unchanged.
- R4: A command is recognised at any bit alignment of the stream, because any rotation of a command byte decodes as that command.
- R5: Gain commands set `gain_o` as follows: 0xD2 sets 0 (3.6 V), 0xD4 sets 1 (2.5 V), 0xD8 sets 2 (5 V).
- R6: Mode commands: 0xE1 sets `low_emi_o`, 0xE2 sets `low_lat_o`, 0x66 sets `cfg_mute_o`. 0xE4 sets `rate_128_o` to the inverse of `strap_i[1]`.
- R7: Command 0xAA returns every configuration field to its strap default.
- R8: A repeating byte that is no rotation of a known command changes no field and never raises `pat_mute_o`.
- R9: `pat_mute_o` rises once a known command has repeated for eight agreeing bits. It falls on the first bit that disagrees. Settings already applied are kept.
- R10: Command 0xAC sets `pd_req_o`. The first disagreeing bit afterwards clears it.
- R11: After LOSS_CYCLES system clocks with no `pdm_clk_i` edge, `pd_req_o` is set and all fields return to strap defaults. The first selected bit after the clock resumes clears `pd_req_o`.
- R12: `lr_sel_i` may change between bits without clearing detection progress. A pattern present on both channels with the same phase keeps its run across the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the PDM clock |
| rst | input | 1 | Synchronous active-high reset |
| pdm_clk_i | input | 1 | PDM bit clock, already synchronised to `clk` |
| pdm_dat_i | input | 1 | PDM data, already synchronised to `clk` |
| lr_sel_i | input | 1 | Channel select: 0 left (rising edge), 1 right (falling edge) |
| strap_i | input | 2 | Latched strap: bit 1 rate (1 = 128x), bit 0 gain (1 = 5 V) |
| gain_o | output | 2 | Gain choice: 0 = 3.6 V, 1 = 2.5 V, 2 = 5 V |
| rate_128_o | output | 1 | 1 selects the 128x rate, 0 the 64x rate |
| low_emi_o | output | 1 | Low-EMI modulation mode |
| low_lat_o | output | 1 | Low-latency mode |
| cfg_mute_o | output | 1 | Persistent mute set by command |
| pat_mute_o | output | 1 | Mute while a known command is repeating |
| pd_req_o | output | 1 | Power-down request |

## Verification
The assertions take for granted three things about the inputs. `pdm_clk_i` holds each level for at least one system clock. The strap changes only while reset is held. Any gain or power-down change must therefore trace back to a decoded command or to clock loss. The bench meets these conditions in three ways. It holds each PDM clock level for two system cycles and changes data only on the opposite phase. It moves the strap only inside its reset task. It lets the PDM clock pause only in the clock-loss test, and only for longer than LOSS_CYCLES.

// File: rtl/pdm_ctl_pkg.sv
package pdm_ctl_pkg;

  typedef enum logic [1:0] {
    GAIN_3V6 = 2'd0,
    GAIN_2V5 = 2'd1,
    GAIN_5V0 = 2'd2
  } gain_e;

  typedef enum logic [3:0] {
    CMD_NONE     = 4'd0,
    CMD_G36      = 4'd1,
    CMD_G25      = 4'd2,
    CMD_G50      = 4'd3,
    CMD_LOWEMI   = 4'd4,
    CMD_LOWLAT   = 4'd5,
    CMD_RATEFLIP = 4'd6,
    CMD_DEFAULTS = 4'd7,
    CMD_MUTE     = 4'd8,
    CMD_STOP     = 4'd9
  } cmd_e;

  typedef struct packed {
    gain_e gain;
    logic  rate_128;
    logic  low_emi;
    logic  low_lat;
    logic  mute;
  } cfg_t;

  localparam int NUM_CODES = 9;
  localparam int BYTE_W    = 8;

  function automatic logic [7:0] code_at(input int idx);
    case (idx)
      0:       return 8'hD2;
      1:       return 8'hD4;
      2:       return 8'hD8;
      3:       return 8'hE1;
      4:       return 8'hE2;
      5:       return 8'hE4;
      6:       return 8'hAA;
      7:       return 8'h66;
      default: return 8'hAC;
    endcase
  endfunction

  function automatic cmd_e cmd_at(input int idx);
    case (idx)
      0:       return CMD_G36;
      1:       return CMD_G25;
      2:       return CMD_G50;
      3:       return CMD_LOWEMI;
      4:       return CMD_LOWLAT;
      5:       return CMD_RATEFLIP;
      6:       return CMD_DEFAULTS;
      7:       return CMD_MUTE;
      default: return CMD_STOP;
    endcase
  endfunction

  function automatic cfg_t strap_cfg(input logic [1:0] s);
    cfg_t c;
    c.gain     = s[0] ? GAIN_5V0 : GAIN_3V6;
    c.rate_128 = s[1];
    c.low_emi  = 1'b0;
    c.low_lat  = 1'b0;
    c.mute     = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/pdm_bit_pick.sv
module pdm_bit_pick #(
  parameter int LOSS_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic pdm_clk,
  input  logic pdm_dat,
  input  logic lr_sel,
  output logic bit_vld,
  output logic bit_val,
  output logic lost
);
  localparam int IW = $clog2(LOSS_CYCLES + 1);

  logic          clk_q;
  logic          rise;
  logic          fall;
  logic [IW-1:0] idle;

  assign rise = pdm_clk & ~clk_q;
  assign fall = ~pdm_clk & clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q   <= 1'b0;
      bit_vld <= 1'b0;
      bit_val <= 1'b0;
      idle    <= '0;
      lost    <= 1'b0;
    end else begin
      clk_q   <= pdm_clk;
      // left channel on the rising edge, right on the falling edge
      bit_vld <= lr_sel ? fall : rise;
      bit_val <= pdm_dat;
      if (rise | fall) begin
        idle <= '0;
        lost <= 1'b0;
      end else begin
        if (idle != IW'(LOSS_CYCLES)) idle <= idle + 1'b1;
        if (idle >= IW'(LOSS_CYCLES - 1)) lost <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pdm_rep_det.sv
module pdm_rep_det
  import pdm_ctl_pkg::*;
#(
  parameter int REPEATS = 129
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bit_vld,
  input  logic bit_val,
  output logic match_stb,
  output cmd_e match_cmd,
  output logic pat_mute,
  output logic run_brk
);
  localparam int AGREE_N = REPEATS * BYTE_W;
  localparam int CW      = $clog2(AGREE_N + 1);
  localparam int FW      = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0]    win;
  logic [BYTE_W-1:0]    win_n;
  logic [FW-1:0]        fill;
  logic [CW-1:0]        agree;
  logic [CW-1:0]        agree_n;
  logic                 filled;
  logic                 same;
  logic [NUM_CODES-1:0] hit;
  cmd_e                 cmd_n;

  assign win_n  = {win[BYTE_W-2:0], bit_val};
  assign filled = (fill == FW'(BYTE_W));
  assign same   = (bit_val == win[BYTE_W-1]);

  always_comb begin
    if (!filled || !same)            agree_n = '0;
    else if (agree == CW'(AGREE_N))  agree_n = agree;
    else                             agree_n = agree + 1'b1;
  end

  // one rotation-insensitive comparator per known command
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    localparam logic [7:0]  CODE = code_at(g);
    localparam logic [15:0] DBL  = {CODE, CODE};
    always_comb begin
      hit[g] = 1'b0;
      for (int r = 0; r < BYTE_W; r++) begin
        if (win_n == DBL[r +: 8]) hit[g] = 1'b1;
      end
    end
  end

  always_comb begin
    cmd_n = CMD_NONE;
    for (int g = 0; g < NUM_CODES; g++) begin
      if (hit[g]) cmd_n = cmd_at(g);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      win       <= '0;
      fill      <= '0;
      agree     <= '0;
      match_stb <= 1'b0;
      match_cmd <= CMD_NONE;
      pat_mute  <= 1'b0;
      run_brk   <= 1'b0;
    end else begin
      match_stb <= 1'b0;
      run_brk   <= 1'b0;
      if (bit_vld) begin
        win      <= win_n;
        agree    <= agree_n;
        if (!filled) fill <= fill + 1'b1;
        run_brk  <= filled & ~same;
        pat_mute <= (agree_n >= CW'(BYTE_W)) && (cmd_n != CMD_NONE);
        if ((agree_n == CW'(AGREE_N)) && (agree != CW'(AGREE_N)) &&
            (cmd_n != CMD_NONE)) begin
          match_stb <= 1'b1;
          match_cmd <= cmd_n;
        end
      end
    end
  end

endmodule

// File: rtl/pdm_cfg_reg.sv
module pdm_cfg_reg
  import pdm_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] strap,
  input  logic       match_stb,
  input  cmd_e       match_cmd,
  input  logic       run_brk,
  input  logic       bit_vld,
  input  logic       lost,
  output cfg_t       cfg,
  output logic       pd_req
);
  cfg_t dflt;
  logic pd_loss;

  assign dflt = strap_cfg(strap);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= dflt;
      pd_req  <= 1'b0;
      pd_loss <= 1'b0;
    end else if (lost) begin
      cfg     <= dflt;
      pd_req  <= 1'b1;
      pd_loss <= 1'b1;
    end else begin
      if (pd_loss && bit_vld) begin
        pd_req  <= 1'b0;
        pd_loss <= 1'b0;
      end
      if (run_brk && !pd_loss) pd_req <= 1'b0;
      if (match_stb) begin
        case (match_cmd)
          CMD_G36:      cfg.gain     <= GAIN_3V6;
          CMD_G25:      cfg.gain     <= GAIN_2V5;
          CMD_G50:      cfg.gain     <= GAIN_5V0;
          CMD_LOWEMI:   cfg.low_emi  <= 1'b1;
          CMD_LOWLAT:   cfg.low_lat  <= 1'b1;
          CMD_RATEFLIP: cfg.rate_128 <= ~dflt.rate_128;
          CMD_DEFAULTS: cfg          <= dflt;
          CMD_MUTE:     cfg.mute     <= 1'b1;
          CMD_STOP:     pd_req       <= 1'b1;
          default:      ;
        endcase
      end
    end
  end

endmodule

// File: rtl/pdm_ctl_decoder.sv
module pdm_ctl_decoder
  import pdm_ctl_pkg::*;
#(
  parameter int REPEATS     = 129,
  parameter int LOSS_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pdm_clk_i,
  input  logic       pdm_dat_i,
  input  logic       lr_sel_i,
  input  logic [1:0] strap_i,
  output logic [1:0] gain_o,
  output logic       rate_128_o,
  output logic       low_emi_o,
  output logic       low_lat_o,
  output logic       cfg_mute_o,
  output logic       pat_mute_o,
  output logic       pd_req_o
);
  logic bit_vld;
  logic bit_val;
  logic lost;
  logic match_stb;
  cmd_e match_cmd;
  logic run_brk;
  cfg_t cfg;

  pdm_bit_pick #(.LOSS_CYCLES(LOSS_CYCLES)) u_pick (
    .clk     (clk),
    .rst     (rst),
    .pdm_clk (pdm_clk_i),
    .pdm_dat (pdm_dat_i),
    .lr_sel  (lr_sel_i),
    .bit_vld (bit_vld),
    .bit_val (bit_val),
    .lost    (lost)
  );

  pdm_rep_det #(.REPEATS(REPEATS)) u_rep (
    .clk       (clk),
    .rst       (rst),
    .clr       (lost),
    .bit_vld   (bit_vld),
    .bit_val   (bit_val),
    .match_stb (match_stb),
    .match_cmd (match_cmd),
    .pat_mute  (pat_mute_o),
    .run_brk   (run_brk)
  );

  pdm_cfg_reg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .strap     (strap_i),
    .match_stb (match_stb),
    .match_cmd (match_cmd),
    .run_brk   (run_brk),
    .bit_vld   (bit_vld),
    .lost      (lost),
    .cfg       (cfg),
    .pd_req    (pd_req_o)
  );

  assign gain_o     = cfg.gain;
  assign rate_128_o = cfg.rate_128;
  assign low_emi_o  = cfg.low_emi;
  assign low_lat_o  = cfg.low_lat;
  assign cfg_mute_o = cfg.mute;

endmodule

// File: rtl/pdm_ctl_decoder_chk.sv
module pdm_ctl_decoder_chk
  import pdm_ctl_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       bit_vld,
  input logic       lost,
  input logic       match_stb,
  input cmd_e       match_cmd,
  input logic       pat_mute,
  input logic       pd_req,
  input logic [1:0] gain,
  input logic [1:0] strap
);

  // R9
  match_mutes_chk: assert property (@(posedge clk) disable iff (rst)
    match_stb |-> pat_mute);

  // R9
  mute_drop_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pat_mute) |-> $past(bit_vld || lost));

  // R5
  gain_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(gain) |-> $past(match_stb || lost));

  // R10
  pd_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_req) |-> $past((match_stb && (match_cmd == CMD_STOP)) || lost));

  // R11
  loss_dflt_chk: assert property (@(posedge clk) disable iff (rst)
    lost |=> (pd_req && (gain == (strap[0] ? 2'd2 : 2'd0))));

  // R2
  bit_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> !bit_vld);

endmodule

bind pdm_ctl_decoder pdm_ctl_decoder_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bit_vld   (bit_vld),
  .lost      (lost),
  .match_stb (match_stb),
  .match_cmd (match_cmd),
  .pat_mute  (pat_mute_o),
  .pd_req    (pd_req_o),
  .gain      (gain_o),
  .strap     (strap_i)
);

// File: tb/pdm_ctl_decoder_tb.sv
module pdm_ctl_decoder_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pdm_clk = 1'b0;
  logic       pdm_dat = 1'b0;
  logic       lr_sel = 1'b0;
  logic [1:0] strap = 2'b00;
  logic [1:0] gain_o;
  logic       rate_128_o, low_emi_o, low_lat_o, cfg_mute_o, pat_mute_o, pd_req_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pdm_ctl_decoder u_dut (
    .clk        (clk),
    .rst        (rst),
    .pdm_clk_i  (pdm_clk),
    .pdm_dat_i  (pdm_dat),
    .lr_sel_i   (lr_sel),
    .strap_i    (strap),
    .gain_o     (gain_o),
    .rate_128_o (rate_128_o),
    .low_emi_o  (low_emi_o),
    .low_lat_o  (low_lat_o),
    .cfg_mute_o (cfg_mute_o),
    .pat_mute_o (pat_mute_o),
    .pd_req_o   (pd_req_o)
  );

  // {code, gain, rate, emi, lat, mute, pd, pat_mute}, strap 00
  localparam logic [15:0] VEC [10] = '{
    {8'hD2, 2'd0, 6'b000001},
    {8'hD4, 2'd1, 6'b000001},
    {8'hD8, 2'd2, 6'b000001},
    {8'hE1, 2'd0, 6'b010001},
    {8'hE2, 2'd0, 6'b001001},
    {8'hE4, 2'd0, 6'b100001},
    {8'h66, 2'd0, 6'b000101},
    {8'hAC, 2'd0, 6'b000011},
    {8'hAA, 2'd0, 6'b000001},
    {8'h13, 2'd0, 6'b000000}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s, input logic lr);
    rst = 1'b1; strap = s; lr_sel = lr; pdm_clk = 1'b0; pdm_dat = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic l, input logic r);
    pdm_dat = l; @(negedge clk);
    pdm_clk = 1'b1; @(negedge clk);
    pdm_dat = r; @(negedge clk);
    pdm_clk = 1'b0; @(negedge clk);
  endtask

  task automatic send_bytes(input logic [7:0] lb, input logic [7:0] rb, input int n);
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--) send_bit(lb[i], rb[i]);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic string vec_tag(input logic [7:0] c);
    case (c)
      8'hD2, 8'hD4, 8'hD8:         return "R5 gain";
      8'hE1, 8'hE2, 8'hE4, 8'h66:  return "R6 mode";
      8'hAC:                       return "R10 stop";
      8'hAA:                       return "R7 defaults";
      default:                     return "R8 unknown";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): got 200000 cycles expected completion sooner");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state for two strap values
    do_reset(2'b11, 1'b0);
    check("R1 gain strap11", gain_o, 2);
    check("R1 rate strap11", rate_128_o, 1);
    check("R1 emi", low_emi_o, 0);
    check("R1 lat", low_lat_o, 0);
    check("R1 mute", cfg_mute_o, 0);
    check("R1 pat", pat_mute_o, 0);
    check("R1 pd", pd_req_o, 0);
    do_reset(2'b00, 1'b0);
    check("R1 gain strap00", gain_o, 0);
    check("R1 rate strap00", rate_128_o, 0);

    // table of commands on the left channel
    for (int v = 0; v < 10; v++) begin
      do_reset(2'b00, 1'b0);
      send_bytes(VEC[v][15:8], 8'h13, 130);
      settle();
      check(vec_tag(VEC[v][15:8]), gain_o, int'(VEC[v][7:6]));
      check(vec_tag(VEC[v][15:8]), rate_128_o, VEC[v][5]);
      check(vec_tag(VEC[v][15:8]), low_emi_o, VEC[v][4]);
      check(vec_tag(VEC[v][15:8]), low_lat_o, VEC[v][3]);
      check(vec_tag(VEC[v][15:8]), cfg_mute_o, VEC[v][2]);
      check(vec_tag(VEC[v][15:8]), pd_req_o, VEC[v][1]);
      check({vec_tag(VEC[v][15:8]), " R9 pat"}, pat_mute_o, VEC[v][0]);
    end

    // R3 threshold: one bit short, then the final bit
    do_reset(2'b00, 1'b0);
    send_bytes(8'hD8, 8'h00, 129);
    for (int i = 7; i >= 1; i--) send_bit(1'(8'hD8 >> i), 1'b0);
    settle();
    check("R3 one bit short gain", gain_o, 0);
    check("R9 mute during run", pat_mute_o, 1);
    send_bit(1'b0, 1'b0);
    settle();
    check("R3 final bit gain", gain_o, 2);

    // R9 early mute and release
    do_reset(2'b00, 1'b0);
    send_bytes(8'hE1, 8'h00, 3);
    settle();
    check("R9 early mute", pat_mute_o, 1);
    check("R9 no early effect", low_emi_o, 0);
    send_bytes(8'h13, 8'h00, 1);
    settle();
    check("R9 release", pat_mute_o, 0);

    // R9 break keeps applied setting
    do_reset(2'b00, 1'b0);
    send_bytes(8'hD4, 8'h00, 130);
    send_bytes(8'h13, 8'h00, 2);
    settle();
    check("R9 kept gain", gain_o, 1);
    check("R9 mute off", pat_mute_o, 0);

    // R10 stop then break
    do_reset(2'b00, 1'b0);
    send_bytes(8'hAC, 8'h00, 130);
    settle();
    check("R10 pd set", pd_req_o, 1);
    send_bytes(8'h13, 8'h00, 2);
    settle();
    check("R10 pd cleared", pd_req_o, 0);

    // R4 misaligned start
    do_reset(2'b00, 1'b0);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b0);
    send_bytes(8'hD4, 8'h00, 132);
    settle();
    check("R4 misaligned gain", gain_o, 1);

    // R2 right channel selection
    do_reset(2'b00, 1'b1);
    send_bytes(8'h13, 8'hE2, 130);
    settle();
    check("R2 right lat", low_lat_o, 1);
    do_reset(2'b00, 1'b0);
    send_bytes(8'h13, 8'hE2, 130);
    settle();
    check("R2 left ignores right lat", low_lat_o, 0);
    check("R2 left ignores right pat", pat_mute_o, 0);

    // R12 channel switch mid-run
    do_reset(2'b00, 1'b0);
    send_bytes(8'hD8, 8'hD8, 65);
    lr_sel = 1'b1;
    send_bytes(8'hD8, 8'hD8, 1);
    settle();
    check("R12 mute kept after switch", pat_mute_o, 1);
    send_bytes(8'hD8, 8'hD8, 65);
    settle();
    check("R12 gain after switch", gain_o, 2);

    // R6 rate flip against a 128x strap
    do_reset(2'b11, 1'b0);
    send_bytes(8'hE4, 8'h00, 130);
    settle();
    check("R6 rate flip strap11", rate_128_o, 0);

    // R7 defaults after several commands
    do_reset(2'b00, 1'b0);
    send_bytes(8'hD4, 8'h00, 131);
    send_bytes(8'hE1, 8'h00, 131);
    send_bytes(8'h66, 8'h00, 131);
    settle();
    check("R7 pre gain", gain_o, 1);
    check("R7 pre emi", low_emi_o, 1);
    check("R7 pre mute", cfg_mute_o, 1);
    send_bytes(8'hAA, 8'h00, 131);
    settle();
    check("R7 gain", gain_o, 0);
    check("R7 emi", low_emi_o, 0);
    check("R7 mute", cfg_mute_o, 0);

    // R11 clock loss
    do_reset(2'b00, 1'b0);
    send_bytes(8'hD8, 8'h00, 131);
    send_bytes(8'hE2, 8'h00, 131);
    settle();
    check("R11 pre gain", gain_o, 2);
    repeat (200) @(negedge clk);
    check("R11 loss pd", pd_req_o, 1);
    check("R11 loss gain", gain_o, 0);
    check("R11 loss lat", low_lat_o, 0);
    check("R11 loss pat", pat_mute_o, 0);
    send_bit(1'b1, 1'b0);
    settle();
    check("R11 resume pd", pd_req_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule